// File: doc/BRIEF.md
# Procedure Call Frame Sequencer

This block builds and tears down procedure stack frames for a processor with sixteen 32-bit registers (r12 argument pointer, r13 frame pointer, r14 stack pointer, r15 program counter) and a 16-bit status word. It supports two call styles and the matching return. A stack-argument call records the argument count on the stack. A list call takes the address of an argument list that already sits in memory. On a call, the block first fetches a save-mask word from the target address. It then stores the selected registers r0..r11, the link registers and a packed status longword. It closes the frame with a zero longword and loads the new pointers.

A return walks the frame from the frame pointer upward. It restores the link registers, the masked registers and the status word. It undoes the alignment padding and, for a stack-argument frame, also pops the argument count and the arguments. Every memory access is one 32-bit longword on a request/ready port. The register file lives inside the block and can be loaded and inspected through a host port while the block is idle.

Top module: `call_frame_seq`

## Requirements
- R1: After reset, busy, done and mem_req are low and the status word reads 0.
- R2: A start with cmd=1 (stack-argument call) or cmd=2 (list call) reads the longword at `target`, and bits 11:0 of that word form the save mask. The frame is then written at descending addresses: the masked registers from r11 down to r0 (a set bit i selects ri), then r15, r13, r12, then the status longword, and last a zero longword.
- R3: A stack-argument call first writes the low 8 bits of `arg_val`, zero-extended, at SP-4, and the new r12 is that address.
- R4: After the optional count push, the two low SP bits are kept as the alignment residue and SP is rounded down to a multiple of 4 before any register is stored.
- R5: The status longword holds the pre-call status word in bits 15:0, the mask in bits 27:16, a 0 in bit 28, the style flag in bit 29 (1 for cmd=1, 0 for cmd=2) and the alignment residue in bits 31:30.
- R6: After a call, r14 and r13 both hold the address of the zero longword, r15 holds `target`+2, and status bits 3:0 are 0 while bits 15:4 are kept.
- R7: A list call writes no count, and its new r12 equals `arg_val`.
- R8: A return (cmd=3) restores r12, r13 and r15 and every masked register from the frame, leaves unmasked registers among r0..r11 unchanged, and restores the status word from the saved low half.
- R9: After a return, r14 = old r13 + 8 + 12 + 4 × (number of mask bits) + residue. For a stack-argument frame, 4 + 4 × (the count byte stored at that address) is added on top.
- R10: A request with mem_ready low stays asserted with the same address and direction until mem_ready is high.
- R11: busy is high from the cycle after an accepted start until the sequence ends. done is then high for exactly one cycle with busy low, and mem_req is never high while busy is low.
- R12: A return makes no memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| cmd | input | 2 | 1 stack-argument call, 2 list call, 3 return |
| arg_val | input | 32 | Argument count (cmd=1) or argument list address (cmd=2) |
| target | input | 32 | Address of the called routine's save-mask word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the longword |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| host_we | input | 1 | Register write from host (ignored while busy) |
| host_waddr | input | 4 | Host write register number |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 4 | Host read register number |
| host_rdata | output | 32 | Host read data |
| psw_we | input | 1 | Status word load (idle only) |
| psw_wdata | input | 16 | Status word load value |
| psw | output | 16 | Current status word |

## Verification
The assertions watch four things on every cycle. A stalled request must hold its address and direction. done must be a lone pulse outside busy, and no request may appear while idle. A return must never issue a write, and every call must end with clear condition bits. The frame contents, the exact ordering of pushed words, the packed status longword and the final pointer arithmetic only show up through the directed scenarios. These scenarios cover an aligned and an unaligned stack, a full and a sparse mask, and the largest argument count. The scenarios also check that registers outside the mask keep the values written before the return.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [1:0] {
    CMD_NONE     = 2'd0,
    CMD_CALL_STK = 2'd1,
    CMD_CALL_LST = 2'd2,
    CMD_RET      = 2'd3
  } cmd_e;

  localparam logic [3:0] REG_AP = 4'd12;
  localparam logic [3:0] REG_FP = 4'd13;
  localparam logic [3:0] REG_SP = 4'd14;
  localparam logic [3:0] REG_PC = 4'd15;

  typedef enum logic [3:0] {
    ST_IDLE, ST_C_MASK, ST_C_CNT, ST_C_ALIGN, ST_C_REG, ST_C_LINK,
    ST_C_STAT, ST_C_ZERO, ST_C_FIN, ST_R_INIT, ST_R_STAT, ST_R_LINK,
    ST_R_REG, ST_R_ALIGN, ST_R_CNT, ST_R_FIN
  } state_e;

  // link slot k: 0 -> PC, 1 -> FP, 2 -> AP (push order; pop runs reversed)
  function automatic logic [3:0] link_reg(input logic [1:0] k);
    case (k)
      2'd0:    link_reg = REG_PC;
      2'd1:    link_reg = REG_FP;
      default: link_reg = REG_AP;
    endcase
  endfunction
endpackage

// File: rtl/cfs_regfile.sv
module cfs_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra0,
  output logic [DW-1:0] rd0,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] rd1
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/cfs_seq.sv
module cfs_seq
  import cfs_pkg::*;
#(
  parameter int DW     = 32,
  parameter int MASK_W = 12,
  localparam int HW    = DW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    cmd,
  input  logic [DW-1:0] arg_val,
  input  logic [DW-1:0] target,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic [3:0]    rf_ra,
  input  logic [DW-1:0] rf_rd,
  output logic          rf_we,
  output logic [3:0]    rf_wa,
  output logic [DW-1:0] rf_wd,
  input  logic          psw_we,
  input  logic [HW-1:0] psw_wdata,
  output logic [HW-1:0] psw
);
  localparam int MISC_PAD = HW - MASK_W - 4;

  state_e              state_q;
  logic [DW-1:0]       sp_q, tmp_q, arg_q, tgt_q;
  logic [MASK_W-1:0]   mask_q;
  logic [1:0]          spa_q, lidx_q;
  logic [3:0]          ridx_q;
  logic                sflag_q, done_q;
  logic [HW-1:0]       psw_q;
  logic [DW-1:0]       sp_dec, sp_inc;
  logic [HW-1:0]       misc;
  logic                acc, bit_sel;

  assign sp_dec  = sp_q - DW'(4);
  assign sp_inc  = sp_q + DW'(4);
  assign bit_sel = mask_q[ridx_q];
  assign misc    = {spa_q, sflag_q, 1'b0, {MISC_PAD{1'b0}}, mask_q};
  assign acc     = mem_req && mem_ready;
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign psw     = psw_q;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = sp_dec;
    mem_wdata = rf_rd;
    rf_ra     = REG_SP;
    rf_we     = 1'b0;
    rf_wa     = REG_SP;
    rf_wd     = sp_q;
    case (state_q)
      ST_C_MASK: begin mem_req = 1'b1; mem_addr = tgt_q; end
      ST_C_CNT: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_wdata = {{(DW-8){1'b0}}, arg_q[7:0]};
      end
      ST_C_REG:  begin rf_ra = ridx_q; mem_req = bit_sel; mem_we = 1'b1; end
      ST_C_LINK: begin rf_ra = link_reg(lidx_q); mem_req = 1'b1; mem_we = 1'b1; end
      ST_C_STAT: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = {misc, psw_q}; end
      ST_C_ZERO: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = '0; end
      ST_C_FIN: begin
        rf_we = 1'b1;
        case (lidx_q)
          2'd0: begin rf_wa = REG_SP; rf_wd = sp_q; end
          2'd1: begin rf_wa = REG_FP; rf_wd = sp_q; end
          2'd2: begin rf_wa = REG_AP; rf_wd = sflag_q ? tmp_q : arg_q; end
          default: begin rf_wa = REG_PC; rf_wd = tgt_q + DW'(2); end
        endcase
      end
      ST_R_INIT: rf_ra = REG_FP;
      ST_R_STAT, ST_R_CNT: begin mem_req = 1'b1; mem_addr = sp_q; end
      ST_R_LINK: begin
        mem_req = 1'b1; mem_addr = sp_q;
        rf_we = acc; rf_wa = link_reg(lidx_q); rf_wd = mem_rdata;
      end
      ST_R_REG: begin
        mem_req = bit_sel; mem_addr = sp_q;
        rf_we = acc; rf_wa = ridx_q; rf_wd = mem_rdata;
      end
      ST_R_FIN: rf_we = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      psw_q   <= '0;
      sp_q    <= '0;
      tmp_q   <= '0;
      arg_q   <= '0;
      tgt_q   <= '0;
      mask_q  <= '0;
      spa_q   <= '0;
      lidx_q  <= '0;
      ridx_q  <= '0;
      sflag_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start && cmd != CMD_NONE) begin
            arg_q   <= arg_val;
            tgt_q   <= target;
            sp_q    <= rf_rd;
            sflag_q <= (cmd_e'(cmd) == CMD_CALL_STK);
            state_q <= (cmd_e'(cmd) == CMD_RET) ? ST_R_INIT : ST_C_MASK;
          end else if (psw_we) begin
            psw_q <= psw_wdata;
          end
        end
        ST_C_MASK: if (acc) begin
          mask_q  <= mem_rdata[MASK_W-1:0];
          state_q <= sflag_q ? ST_C_CNT : ST_C_ALIGN;
        end
        ST_C_CNT: if (acc) begin
          sp_q    <= sp_dec;
          tmp_q   <= sp_dec;
          state_q <= ST_C_ALIGN;
        end
        ST_C_ALIGN: begin
          spa_q   <= sp_q[1:0];
          sp_q    <= {sp_q[DW-1:2], 2'b00};
          ridx_q  <= 4'(MASK_W - 1);
          state_q <= ST_C_REG;
        end
        ST_C_REG: if (!bit_sel || acc) begin
          if (acc) sp_q <= sp_dec;
          if (ridx_q == 4'd0) begin
            lidx_q  <= 2'd0;
            state_q <= ST_C_LINK;
          end else begin
            ridx_q <= ridx_q - 4'd1;
          end
        end
        ST_C_LINK: if (acc) begin
          sp_q <= sp_dec;
          if (lidx_q == 2'd2) state_q <= ST_C_STAT;
          else lidx_q <= lidx_q + 2'd1;
        end
        ST_C_STAT: if (acc) begin
          sp_q       <= sp_dec;
          psw_q[3:0] <= 4'd0;
          state_q    <= ST_C_ZERO;
        end
        ST_C_ZERO: if (acc) begin
          sp_q    <= sp_dec;
          lidx_q  <= 2'd0;
          state_q <= ST_C_FIN;
        end
        ST_C_FIN: begin
          lidx_q <= lidx_q + 2'd1;
          if (lidx_q == 2'd3) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_R_INIT: begin
          sp_q    <= rf_rd + DW'(4);
          state_q <= ST_R_STAT;
        end
        ST_R_STAT: if (acc) begin
          tmp_q   <= mem_rdata;
          mask_q  <= mem_rdata[HW +: MASK_W];
          sflag_q <= mem_rdata[DW-3];
          spa_q   <= mem_rdata[DW-1:DW-2];
          sp_q    <= sp_inc;
          lidx_q  <= 2'd2;
          state_q <= ST_R_LINK;
        end
        ST_R_LINK: if (acc) begin
          sp_q <= sp_inc;
          if (lidx_q == 2'd0) begin
            ridx_q  <= 4'd0;
            state_q <= ST_R_REG;
          end else begin
            lidx_q <= lidx_q - 2'd1;
          end
        end
        ST_R_REG: if (!bit_sel || acc) begin
          if (acc) sp_q <= sp_inc;
          if (ridx_q == 4'(MASK_W - 1)) state_q <= ST_R_ALIGN;
          else ridx_q <= ridx_q + 4'd1;
        end
        ST_R_ALIGN: begin
          sp_q    <= sp_q + DW'(spa_q);
          psw_q   <= tmp_q[HW-1:0];
          state_q <= sflag_q ? ST_R_CNT : ST_R_FIN;
        end
        ST_R_CNT: if (acc) begin
          sp_q    <= sp_inc + {{(DW-10){1'b0}}, mem_rdata[7:0], 2'b00};
          state_q <= ST_R_FIN;
        end
        ST_R_FIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/call_frame_seq.sv
module call_frame_seq #(
  parameter int DW     = 32,
  parameter int NREG   = 16,
  parameter int MASK_W = 12,
  localparam int HW    = DW / 2,
  localparam int RAW   = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [1:0]     cmd,
  input  logic [DW-1:0]  arg_val,
  input  logic [DW-1:0]  target,
  output logic           busy,
  output logic           done,
  output logic           mem_req,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ready,
  input  logic           host_we,
  input  logic [RAW-1:0] host_waddr,
  input  logic [DW-1:0]  host_wdata,
  input  logic [RAW-1:0] host_raddr,
  output logic [DW-1:0]  host_rdata,
  input  logic           psw_we,
  input  logic [HW-1:0]  psw_wdata,
  output logic [HW-1:0]  psw
);
  logic [RAW-1:0] seq_ra, seq_wa, rf_wa;
  logic [DW-1:0]  seq_rd, seq_wd, rf_wd;
  logic           seq_we, rf_we;

  cfs_seq #(.DW(DW), .MASK_W(MASK_W)) seq_i (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd),
    .arg_val(arg_val), .target(target), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .rf_ra(seq_ra), .rf_rd(seq_rd), .rf_we(seq_we), .rf_wa(seq_wa),
    .rf_wd(seq_wd), .psw_we(psw_we), .psw_wdata(psw_wdata), .psw(psw)
  );

  assign rf_we = busy ? seq_we : host_we;
  assign rf_wa = busy ? seq_wa : host_waddr;
  assign rf_wd = busy ? seq_wd : host_wdata;

  cfs_regfile #(.NREG(NREG), .DW(DW)) rf_i (
    .clk(clk), .we(rf_we), .wa(rf_wa), .wd(rf_wd),
    .ra0(seq_ra), .rd0(seq_rd), .ra1(host_raddr), .rd1(host_rdata)
  );
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
  parameter int DW = 32,
  parameter int HW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [1:0]    cmd,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [DW-1:0] mem_addr,
  input logic [HW-1:0] psw
);
  logic last_ret;

  always_ff @(posedge clk) begin
    if (rst) last_ret <= 1'b0;
    else if (start && !busy && cmd != 2'd0) last_ret <= (cmd == 2'd3);
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_ret_no_write_R12: assert property (@(posedge clk) disable iff (rst)
    busy && last_ret |-> !(mem_req && mem_we));

  assert_flags_clear_R6: assert property (@(posedge clk) disable iff (rst)
    done && !last_ret |-> psw[3:0] == 4'd0);
endmodule

bind call_frame_seq cfs_checker #(.DW(DW), .HW(HW)) chk_i (
  .clk(clk), .rst(rst), .start(start), .cmd(cmd), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .psw(psw)
);

// File: tb/call_frame_seq_tb_top.sv
`timescale 1ns/1ps
module call_frame_seq_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, start, busy, done, mem_req, mem_we, mem_ready;
  logic [1:0]  cmd;
  logic [31:0] arg_val, target, mem_addr, mem_wdata, mem_rdata;
  logic        host_we, psw_we;
  logic [3:0]  host_waddr, host_raddr;
  logic [31:0] host_wdata, host_rdata;
  logic [15:0] psw_wdata, psw;

  call_frame_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .arg_val(arg_val),
    .target(target), .busy(busy), .done(done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .host_we(host_we),
    .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .psw_we(psw_we), .psw_wdata(psw_wdata), .psw(psw)
  );

  int n_chk = 0, n_err = 0;
  logic [31:0] mem [0:1023];
  logic        tb_we;
  logic [9:0]  tb_idx;
  logic [31:0] tb_data;
  int          wr_total = 0;
  int          cyc = 0;
  logic [3:0]  rdy_cnt = 4'd0;

  always @(posedge clk) begin
    if (tb_we) mem[tb_idx] <= tb_data;
    else if (mem_req && mem_we && mem_ready) mem[mem_addr[11:2]] <= mem_wdata;
    if (mem_req && mem_we && mem_ready) wr_total <= wr_total + 1;
  end
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(negedge clk) begin
    rdy_cnt   <= rdy_cnt + 4'd1;
    mem_ready <= (rdy_cnt[1:0] != 2'd2);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 150000) begin
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err + 1);
      $finish;
    end
  end

  logic [31:0] exp_r [16];
  logic [31:0] sv_r  [16];
  logic [11:0] sv_mask;
  logic [15:0] sv_psw;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_reg(input int i, input logic [31:0] v);
    @(negedge clk);
    host_we = 1'b1; host_waddr = 4'(i); host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
    exp_r[i] = v;
  endtask

  task automatic get_reg(input int i, output logic [31:0] v);
    host_raddr = 4'(i);
    #1;
    v = host_rdata;
  endtask

  task automatic put_mem(input logic [31:0] addr, input logic [31:0] v);
    @(negedge clk);
    tb_we = 1'b1; tb_idx = addr[11:2]; tb_data = v;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic run_cmd(input logic [1:0] c, input logic [31:0] a, input logic [31:0] t);
    int w = 0;
    @(negedge clk);
    start = 1'b1; cmd = c; arg_val = a; target = t;
    @(negedge clk);
    start = 1'b0; cmd = 2'd0;
    check("R11 busy after start", {31'd0, busy}, 32'd1);
    while (done !== 1'b1 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    check("R11 done seen", {31'd0, done}, 32'd1);
    check("R11 busy low at done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    check("R11 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic setup_regs(input logic [7:0] seed);
    for (int i = 0; i < 16; i++)
      if (i != 14) set_reg(i, {seed, 4'(i), 20'h5A3C1} ^ 32'(i * 7));
  endtask

  task automatic do_call(input int style, input logic [31:0] sp0, input logic [31:0] maskw,
                         input logic [31:0] argv, input logic [31:0] tgt, input logic [15:0] psw0);
    logic [31:0] a, apx, v;
    logic [1:0]  spa;
    set_reg(14, sp0);
    @(negedge clk); psw_we = 1'b1; psw_wdata = psw0;
    @(negedge clk); psw_we = 1'b0;
    put_mem(tgt, maskw);
    for (int i = 0; i < 16; i++) sv_r[i] = exp_r[i];
    sv_mask = maskw[11:0];
    sv_psw  = psw0;
    run_cmd(2'(style), argv, tgt);
    a = sp0; apx = 32'd0;
    if (style == 1) begin
      a = a - 32'd4;
      check("R3 count word", mem[a[11:2]], {24'd0, argv[7:0]});
      apx = a;
    end
    spa = a[1:0];
    a = {a[31:2], 2'b00};
    for (int i = 11; i >= 0; i--)
      if (sv_mask[i]) begin
        a = a - 32'd4;
        check($sformatf("R2 saved r%0d", i), mem[a[11:2]], sv_r[i]);
      end
    a = a - 32'd4; check("R2 saved pc", mem[a[11:2]], sv_r[15]);
    a = a - 32'd4; check("R2 saved fp", mem[a[11:2]], sv_r[13]);
    a = a - 32'd4; check("R2 saved ap", mem[a[11:2]], sv_r[12]);
    a = a - 32'd4;
    check("R5 R4 status longword", mem[a[11:2]],
          {spa, (style == 1), 1'b0, sv_mask, psw0});
    a = a - 32'd4; check("R2 zero marker", mem[a[11:2]], 32'd0);
    get_reg(14, v); check("R6 sp", v, a);
    get_reg(13, v); check("R6 fp", v, a);
    get_reg(12, v);
    if (style == 1) check("R3 ap", v, apx);
    else            check("R7 ap", v, argv);
    get_reg(15, v); check("R6 pc", v, tgt + 32'd2);
    check("R6 psw flags", {16'd0, psw}, {16'd0, psw0[15:4], 4'd0});
  endtask

  task automatic do_ret(input logic [31:0] exp_sp);
    logic [31:0] v;
    int w0;
    for (int i = 0; i < 16; i++)
      if (i != 13 && i != 14) set_reg(i, 32'hC0DE_0000 + 32'(i));
    w0 = wr_total;
    run_cmd(2'd3, 32'd0, 32'd0);
    check("R12 no writes on return", 32'(wr_total - w0), 32'd0);
    for (int i = 0; i < 12; i++) begin
      get_reg(i, v);
      check($sformatf("R8 r%0d", i), v, sv_mask[i] ? sv_r[i] : exp_r[i]);
    end
    get_reg(12, v); check("R8 ap", v, sv_r[12]);
    get_reg(13, v); check("R8 fp", v, sv_r[13]);
    get_reg(15, v); check("R8 pc", v, sv_r[15]);
    get_reg(14, v); check("R9 sp", v, exp_sp);
    check("R8 psw", {16'd0, psw}, {16'd0, sv_psw});
  endtask

  task automatic t_reset;
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    check("R1 psw", {16'd0, psw}, 32'd0);
  endtask

  task automatic t_stack_call_aligned;
    setup_regs(8'h11);
    do_call(1, 32'h0000_0F00, 32'hABCD_F0A5, 32'd3, 32'h0000_0100, 16'h002F);
    do_ret(32'h0000_0F00 + 32'd12);
  endtask

  task automatic t_list_call_unaligned;
    setup_regs(8'h22);
    do_call(2, 32'h0000_0EFE, 32'h0000_0FFF, 32'h0000_0200, 32'h0000_0140, 16'h801A);
    do_ret(32'h0000_0EFE);
  endtask

  task automatic t_stack_call_max_count;
    setup_regs(8'h33);
    do_call(1, 32'h0000_0C03, 32'h0000_0801, 32'h0000_01FF, 32'h0000_0180, 16'h0005);
    do_ret(32'h0000_0C03 + 32'd1020);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; cmd = 2'd0; arg_val = '0; target = '0;
    host_we = 1'b0; host_waddr = '0; host_wdata = '0; host_raddr = '0;
    psw_we = 1'b0; psw_wdata = '0; tb_we = 1'b0; tb_idx = '0; tb_data = '0;
    mem_ready = 1'b1;
    for (int i = 0; i < 16; i++) exp_r[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stack_call_aligned();
    t_list_call_unaligned();
    t_stack_call_max_count();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule